// File: doc/BRIEF.md
# Peripheral DMA Channel with Queued Reload

This block is one channel of a peripheral DMA engine. It moves data between a peripheral's data register and system memory, in either direction, with no processor help once it is set up and enabled. Every peripheral request causes exactly one memory access of the chosen width: a byte, a half-word or a word. After each beat the channel steps its memory address by the access width and lowers its remaining count by one. A full controller places many copies of this channel side by side. A duplex serial peripheral takes two copies, one for each direction, and a converter takes one.

The channel keeps two address/count pairs: the active buffer and a queued buffer. When the last beat of the active buffer completes, the queued pair moves into the active pair on the same clock edge. The processor can therefore refill the queue at any time while the active buffer is still running, so buffer refill has no hard real-time deadline. The same load also happens if the channel is enabled and idle with an empty active buffer and a non-empty queue. When both buffers are empty, the channel stops and raises a sticky completion flag. A second sticky flag records each reload.

The peripheral side uses a request/acknowledge handshake. The peripheral holds `per_req` high for as long as it wants a beat. The channel answers with a one-cycle `per_ack` pulse, and the peripheral drops or renews its request after seeing that pulse. The memory side uses valid/ready. The channel holds `mem_valid` and every access field steady until the cycle in which `mem_ready` is high, so memory can stall the channel for as long as it needs. The peripheral is never acknowledged before memory has accepted the beat.

Top module: `pdma_channel`

## Requirements
- R1: After reset, `mem_valid`, `per_ack`, `done_flag`, `reload_flag`, `cur_count` and `next_count` are all zero.
- R2: With control bit 1 at 0 (peripheral to memory), each request produces one memory write. The write goes to the current address and carries the `per_rx_data` value present when the beat started. `per_ack` pulses in the cycle after the `mem_ready` handshake.
- R3: With control bit 1 at 1 (memory to peripheral), each request produces one memory read. `per_tx_data` carries the read data while `per_ack` is high.
- R4: Control bits 3:2 set the size code (0 byte, 1 half-word, 2 word), which appears on `mem_size`. Each completed beat adds 1, 2 or 4 to the current address and subtracts one from the current count.
- R5: There is one memory access per request. No access starts while `per_req` is low, while control bit 0 (enable) is 0, or while the current count is zero.
- R6: While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` hold steady. With a memory latency of L idle cycles, `per_ack` rises 2+L cycles after the request is raised.
- R7: On the last beat of a buffer with a non-zero next count, the next address and count are copied into the current pair on the same edge, `next_count` becomes zero and `reload_flag` is set.
- R8: On the last beat of a buffer with a zero next count, `cur_count` becomes zero, `done_flag` is set, and no further memory access is made.
- R9: A register write to the next count (selector 4) on the edge of a reload is kept as the new next count rather than being cleared.
- R10: A write to selector 5 clears `done_flag` if data bit 0 is 1 and clears `reload_flag` if data bit 1 is 1. Flags whose bit is 0 are left unchanged.
- R11: An enabled, idle channel with a zero current count and a non-zero next count loads the next pair into the current pair.

Register selectors on `cfg_addr`: 0 control, 1 current address, 2 current count, 3 next address, 4 next count, 5 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register selector |
| cfg_wdata | input | ADDR_W | Register write data |
| per_req | input | 1 | Peripheral beat request |
| per_rx_data | input | DATA_W | Data from the peripheral (peripheral to memory) |
| per_ack | output | 1 | One-cycle beat acknowledge |
| per_tx_data | output | DATA_W | Data to the peripheral, valid with `per_ack` |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_write | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| cur_count | output | CNT_W | Remaining beats in the active buffer |
| next_count | output | CNT_W | Beats queued in the next buffer |
| done_flag | output | 1 | Sticky: both buffers drained |
| reload_flag | output | 1 | Sticky: next buffer was loaded |

## Verification
The hardest case to reach from the ports is a write to the next count that lands on the very edge where the last beat retires and the reload happens. The bench creates it by driving the register write in the same cycle in which it first sees `per_ack` high. That acknowledge cycle is the one whose closing edge performs the reload. Memory latency is also varied, so that the stall-hold rules and the request-to-acknowledge timing are exercised with back-pressure as well as without it.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } beat_size_e;

  typedef enum logic [2:0] {
    SEL_CTRL     = 3'd0,
    SEL_CUR_ADDR = 3'd1,
    SEL_CUR_CNT  = 3'd2,
    SEL_NXT_ADDR = 3'd3,
    SEL_NXT_CNT  = 3'd4,
    SEL_FLAG_CLR = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_MEM  = 2'd1,
    XS_ACK  = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic [1:0] size;
    logic       m2p;
    logic       enable;
  } chan_ctrl_t;

  // Byte stride of one beat; the reserved code 3 behaves as a word.
  function automatic logic [3:0] beat_stride(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: beat_stride = 4'd1;
      SZ_HALF: beat_stride = 4'd2;
      default: beat_stride = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              beat_done,
  input  logic              xfer_busy,
  output chan_ctrl_t        ctrl,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              done_flag,
  output logic              reload_flag
);

  logic [ADDR_W-1:0] nxt_addr;
  logic wr_ctrl, wr_cur_addr, wr_cur_cnt, wr_nxt_addr, wr_nxt_cnt, wr_clr;
  logic last_beat, idle_load, do_reload, drained;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    wr_ctrl     = cfg_we && (cfg_addr == SEL_CTRL);
    wr_cur_addr = cfg_we && (cfg_addr == SEL_CUR_ADDR);
    wr_cur_cnt  = cfg_we && (cfg_addr == SEL_CUR_CNT);
    wr_nxt_addr = cfg_we && (cfg_addr == SEL_NXT_ADDR);
    wr_nxt_cnt  = cfg_we && (cfg_addr == SEL_NXT_CNT);
    wr_clr      = cfg_we && (cfg_addr == SEL_FLAG_CLR);
    stride      = ADDR_W'(beat_stride(ctrl.size));
    last_beat   = beat_done && (cur_cnt == CNT_W'(1));
    idle_load   = ctrl.enable && !xfer_busy && (cur_cnt == '0);
    do_reload   = (last_beat || idle_load) && (nxt_cnt != '0);
    drained     = last_beat && (nxt_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= chan_ctrl_t'(cfg_wdata[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else begin
      if (wr_cur_addr)     cur_addr <= cfg_wdata;
      else if (do_reload)  cur_addr <= nxt_addr;
      else if (beat_done)  cur_addr <= cur_addr + stride;

      if (wr_cur_cnt)      cur_cnt <= cfg_wdata[CNT_W-1:0];
      else if (do_reload)  cur_cnt <= nxt_cnt;
      else if (beat_done && cur_cnt != '0) cur_cnt <= cur_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_addr <= '0;
      nxt_cnt  <= '0;
    end else begin
      if (wr_nxt_addr) nxt_addr <= cfg_wdata;
      if (wr_nxt_cnt)      nxt_cnt <= cfg_wdata[CNT_W-1:0];
      else if (do_reload)  nxt_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag   <= 1'b0;
      reload_flag <= 1'b0;
    end else begin
      if (drained)                    done_flag <= 1'b1;
      else if (wr_clr && cfg_wdata[0]) done_flag <= 1'b0;
      if (do_reload)                  reload_flag <= 1'b1;
      else if (wr_clr && cfg_wdata[1]) reload_flag <= 1'b0;
    end
  end

  // R7: an end-of-buffer reload moves the queue forward and empties it
  p_reload_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && nxt_cnt != '0 && !cfg_we) |=>
      (nxt_cnt == '0 && cur_cnt == $past(nxt_cnt) && cur_addr == $past(nxt_addr) && reload_flag));

  // R8: draining both buffers leaves an empty channel with the flag up
  p_drain_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && !cfg_we) |=> (done_flag && cur_cnt == '0));

  // R9: a queue write in a reload cycle survives the reload
  p_next_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_reload && wr_nxt_cnt) |=> (nxt_cnt == $past(cfg_wdata[CNT_W-1:0])));

endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              beat_done,
  output logic              xfer_busy
);

  xfer_state_e       state;
  logic              start;
  logic [DATA_W-1:0] rdata_q;

  assign start = (state == XS_IDLE) && ctrl.enable && per_req && (cur_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      mem_addr  <= '0;
      mem_write <= 1'b0;
      mem_size  <= '0;
      mem_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        XS_IDLE: if (start) begin
          state     <= XS_MEM;
          mem_addr  <= cur_addr;
          mem_write <= !ctrl.m2p;
          mem_size  <= ctrl.size;
          mem_wdata <= per_rx_data;
        end
        XS_MEM: if (mem_ready) begin
          state <= XS_ACK;
          if (!mem_write) rdata_q <= mem_rdata;
        end
        XS_ACK:  state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign mem_valid   = (state == XS_MEM);
  assign per_ack     = (state == XS_ACK);
  assign beat_done   = (state == XS_ACK);
  assign per_tx_data = rdata_q;
  assign xfer_busy   = (state != XS_IDLE);

  // R6: a stalled access keeps every field steady
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) &&
       $stable(mem_size) && $stable(mem_wdata)));

  // R5: one handshake ends the access
  p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R5: an access only opens in answer to a request
  p_access_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(per_req));

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  cur_count,
  output logic [CNT_W-1:0]  next_count,
  output logic              done_flag,
  output logic              reload_flag
);

  chan_ctrl_t        ctrl;
  logic [ADDR_W-1:0] cur_addr;
  logic              beat_done, xfer_busy;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .beat_done(beat_done), .xfer_busy(xfer_busy),
    .ctrl(ctrl), .cur_addr(cur_addr), .cur_cnt(cur_count), .nxt_cnt(next_count),
    .done_flag(done_flag), .reload_flag(reload_flag)
  );

  pdma_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .ctrl(ctrl), .cur_addr(cur_addr), .cur_cnt(cur_count),
    .per_req(per_req), .per_rx_data(per_rx_data),
    .per_ack(per_ack), .per_tx_data(per_tx_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .beat_done(beat_done), .xfer_busy(xfer_busy)
  );

  // R2: acknowledge only follows an accepted memory beat
  p_ack_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> $past(mem_valid && mem_ready));

  // R2: write data is the peripheral word present when the beat opened
  p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_valid) && mem_write) |-> (mem_wdata == $past(per_rx_data)));

endmodule

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        per_req = 1'b0;
  logic [31:0] per_rx_data = '0;
  logic        per_ack;
  logic [31:0] per_tx_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [15:0] cur_count, next_count;
  logic        done_flag, reload_flag;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  int acc_n = 0;
  int cycles = 0;
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  logic        log_wr   [0:63];
  logic [1:0]  log_size [0:63];

  always #4 clk = ~clk;

  pdma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .per_req(per_req), .per_rx_data(per_rx_data), .per_ack(per_ack), .per_tx_data(per_tx_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_count(cur_count), .next_count(next_count), .done_flag(done_flag), .reload_flag(reload_flag)
  );

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  // Memory model: answers after mem_lat idle cycles, logs every accepted beat.
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (wait_cnt >= mem_lat) begin
        mem_ready = 1'b1;
        mem_rdata = rd_pattern(mem_addr);
        log_addr[acc_n % 64] = mem_addr;
        log_data[acc_n % 64] = mem_wdata;
        log_wr[acc_n % 64]   = mem_write;
        log_size[acc_n % 64] = mem_size;
        acc_n++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_beat(input logic [31:0] rx, output logic [31:0] tx, output int cyc,
                         input bit wr_next, input logic [31:0] nval);
    @(negedge clk);
    per_req = 1'b1; per_rx_data = rx; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (per_ack) break;
      if (cyc > 60) break;
    end
    tx = per_tx_data;
    per_req = 1'b0;
    if (wr_next) begin cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = nval; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mem_valid", {31'b0, mem_valid}, 0);
    chk("R1 per_ack", {31'b0, per_ack}, 0);
    chk("R1 done_flag", {31'b0, done_flag}, 0);
    chk("R1 reload_flag", {31'b0, reload_flag}, 0);
    chk("R1 cur_count", {16'b0, cur_count}, 0);
    chk("R1 next_count", {16'b0, next_count}, 0);
  endtask

  task automatic t_p2m_word;
    logic [31:0] tx; int cyc; int base;
    mem_lat = 0;
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd0, 32'h9);               // enable, peripheral->memory, word
    base = acc_n;
    for (int i = 0; i < 3; i++) begin
      do_beat(32'hC0DE_0000 + i, tx, cyc, 1'b0, 0);
      chk("R2 ack timing", cyc, 2);
      chk("R4 count after beat", {16'b0, cur_count}, 2 - i);
    end
    chk("R5 one access per request", acc_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 write flag", {31'b0, log_wr[base + i]}, 1);
      chk("R4 word address", log_addr[base + i], 32'h100 + 4 * i);
      chk("R2 write data", log_data[base + i], 32'hC0DE_0000 + i);
      chk("R4 size code", {30'b0, log_size[base + i]}, 2);
    end
    chk("R8 done after drain", {31'b0, done_flag}, 1);
    // R8: further requests are ignored
    per_req = 1'b1;
    repeat (8) @(negedge clk);
    per_req = 1'b0;
    chk("R8 no access after drain", acc_n - base, 3);
    chk("R8 count stays zero", {16'b0, cur_count}, 0);
  endtask

  task automatic t_m2p_half;
    logic [31:0] tx; int cyc; int base;
    wr_reg(3'd5, 32'h3);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h200);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd0, 32'h7);               // enable, memory->peripheral, half
    base = acc_n;
    for (int i = 0; i < 2; i++) begin
      do_beat(32'h0, tx, cyc, 1'b0, 0);
      chk("R3 read data to peripheral", tx, rd_pattern(32'h200 + 2 * i));
      chk("R3 read flag", {31'b0, log_wr[base + i]}, 0);
      chk("R4 half address", log_addr[base + i], 32'h200 + 2 * i);
    end
  endtask

  task automatic t_byte_stall;
    logic [31:0] tx; int cyc; int base;
    mem_lat = 3;
    wr_reg(3'd5, 32'h3);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h301);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd0, 32'h1);               // enable, peripheral->memory, byte
    base = acc_n;
    for (int i = 0; i < 2; i++) begin
      do_beat(32'h55 + i, tx, cyc, 1'b0, 0);
      chk("R6 ack after stalled ready", cyc, 5);
      chk("R4 byte address", log_addr[base + i], 32'h301 + i);
      chk("R6 data held through stall", log_data[base + i], 32'h55 + i);
    end
    mem_lat = 0;
  endtask

  task automatic t_gating;
    int base;
    wr_reg(3'd5, 32'h3);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h400);
    wr_reg(3'd2, 32'd4);
    base = acc_n;
    per_req = 1'b1;                     // disabled: request ignored
    repeat (10) @(negedge clk);
    per_req = 1'b0;
    chk("R5 no access while disabled", acc_n - base, 0);
    wr_reg(3'd0, 32'h9);
    repeat (10) @(negedge clk);         // enabled, no request
    chk("R5 no access without request", acc_n - base, 0);
    wr_reg(3'd2, 32'd0);
    per_req = 1'b1;                     // zero count
    repeat (10) @(negedge clk);
    per_req = 1'b0;
    chk("R5 no access with zero count", acc_n - base, 0);
    wr_reg(3'd3, 32'h700);
    wr_reg(3'd4, 32'd1);
    @(negedge clk);
    chk("R11 idle load current", {16'b0, cur_count}, 1);
    chk("R11 idle load empties queue", {16'b0, next_count}, 0);
  endtask

  task automatic t_reload;
    logic [31:0] tx; int cyc; int base;
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd5, 32'h3);
    wr_reg(3'd1, 32'h800);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'h900);
    wr_reg(3'd4, 32'd2);
    wr_reg(3'd0, 32'h9);
    base = acc_n;
    do_beat(32'h1, tx, cyc, 1'b0, 0);
    chk("R7 no reload mid buffer", {31'b0, reload_flag}, 0);
    do_beat(32'h2, tx, cyc, 1'b0, 0);
    chk("R7 current count reloaded", {16'b0, cur_count}, 2);
    chk("R7 next count cleared", {16'b0, next_count}, 0);
    chk("R7 reload flag", {31'b0, reload_flag}, 1);
    chk("R7 no done on reload", {31'b0, done_flag}, 0);
    do_beat(32'h3, tx, cyc, 1'b0, 0);
    chk("R7 next buffer address", log_addr[base + 2], 32'h900);
    do_beat(32'h4, tx, cyc, 1'b0, 0);
    chk("R8 done after second buffer", {31'b0, done_flag}, 1);
    wr_reg(3'd5, 32'h1);
    chk("R10 done cleared", {31'b0, done_flag}, 0);
    chk("R10 reload kept", {31'b0, reload_flag}, 1);
    wr_reg(3'd5, 32'h2);
    chk("R10 reload cleared", {31'b0, reload_flag}, 0);
  endtask

  task automatic t_reload_collision;
    logic [31:0] tx; int cyc; int base;
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'hA00);
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd3, 32'hB00);
    wr_reg(3'd4, 32'd1);
    wr_reg(3'd0, 32'h9);
    base = acc_n;
    do_beat(32'h7, tx, cyc, 1'b1, 32'd5);
    chk("R9 reloaded count", {16'b0, cur_count}, 1);
    chk("R9 queued write kept", {16'b0, next_count}, 5);
    do_beat(32'h8, tx, cyc, 1'b0, 0);
    chk("R9 next buffer address", log_addr[base + 1], 32'hB00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_p2m_word;
    t_m2p_half;
    t_byte_stall;
    t_gating;
    t_reload;
    t_reload_collision;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule